// File: doc/BRIEF.md
# Snooping Bus Arbiter With Cache-to-Cache Transfer

This block is the single central controller of a shared coherence bus that links four private cache controllers with one off-chip memory port. It hands the bus to one cache at a time, rotating fairly among the requesters. The grant stays with that cache until the cache hands it back. When the owner issues a read or invalidate command, the arbiter broadcasts the command and line address to all caches for one cycle so that they can snoop it, then gathers their answers.

If any other cache reports that it holds a valid copy (a plain "have data" flag) or a dirty copy (a "must write back" flag), the arbiter picks exactly one of them. It strobes that cache, forwards its line to the owner and tells the owner that the data came from a peer cache. A dirty supplier's line is also written to memory in the same cycle. With no snoop responder the arbiter fetches the line from memory and tells the owner that memory answered. An invalidate gets only a command acknowledge. A write-back command from the owner goes straight to memory.

Top module: `snoop_bus_arbiter`

## Requirements
- R1: At most one cache holds the grant. A new grant goes to the first requesting cache after the previous owner in ascending index order, wrapping from 3 to 0. After reset, cache 0 is searched first.
- R2: The grant stays on the owner for as long as the owner's command is not 000 (release). It drops in the cycle after the owner drives 000.
- R3: A command of 001 (read shared), 010 (read exclusive) or 011 (invalidate) from the owner is broadcast on the bus command and address outputs with the bus-valid strobe high for exactly one cycle.
- R4: Snoop flags are sampled in the bus-valid cycle. The owner's own flags are ignored. Among the other caches that raise either flag, the one with the lowest index is chosen, and it alone receives the send strobe.
- R5: On a peer supply, the owner receives the peer-received and command-received strobes in the same cycle as the supplier's send strobe, with the supplier's line on the read data output. No memory read is issued.
- R6: If the chosen supplier raised the write-back flag, a memory write of its line to the snooped address occurs in the same cycle as the peer delivery. Otherwise no memory write occurs.
- R7: With no peer responder, a single memory read of the snooped address is issued. The cycle after memory data is valid, the owner receives memory-ready with command-received and the memory line.
- R8: An invalidate (011) is answered with command-received only. There is no send strobe, no peer-received, no memory-ready and no memory access.
- R9: A write-back command (111) causes one memory write of the owner's write data to the owner's address. There is no broadcast and no acknowledge.
- R10: A peer delivery is acknowledged one cycle after the bus-valid strobe. A memory fetch is acknowledged MEM_LAT+2 cycles after it, given a memory that returns data MEM_LAT cycles after the read pulse.
- R11: After reset, the grant, all strobes, all acknowledges and both memory commands are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | Per-cache bus request |
| cmd_in | input | 3*N | Per-cache command (000 release, 001, 010, 011, 111) |
| addr_in | input | AW*N | Per-cache line address |
| wdata_in | input | DW*N | Per-cache write-back data |
| gnt | output | N | One-hot bus grant |
| bus_valid | output | 1 | Snoop broadcast strobe |
| bus_cmd | output | 3 | Broadcast command |
| bus_addr | output | AW | Broadcast address |
| snp_avail | input | N | Snoop: clean copy can be supplied |
| snp_wb | input | N | Snoop: dirty copy, supply and write back |
| snp_data | input | DW*N | Per-cache snoop supply line |
| str_send | output | N | Strobe to the chosen supplier |
| str_rec | output | N | Owner: data came from a peer |
| cmd_rcv | output | N | Owner: command acknowledged |
| mdata_rdy | output | N | Owner: data came from memory |
| bus_rdata | output | DW | Line delivered to the owner |
| mem_rd | output | 1 | Memory read pulse |
| mem_wr | output | 1 | Memory write pulse |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_rvld | input | 1 | Memory read data valid |

## Verification
Delivery of a line to the owner and the write of that same line to memory fall in one cycle when the chosen supplier raised the dirty flag. Directed cases and random cases provoke this with write-back flags on one or more caches, sometimes on the owner itself and sometimes below or above a clean responder. The bench judges the overlap by requiring the memory write, the send strobe and the peer-received acknowledge in the same cycle, with equal data, and the memory write address equal to the broadcast address. It also requires no memory write when the lowest responder was clean.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam logic [2:0] CMD_REL = 3'b000;
  localparam logic [2:0] CMD_RDS = 3'b001;
  localparam logic [2:0] CMD_RDX = 3'b010;
  localparam logic [2:0] CMD_INV = 3'b011;
  localparam logic [2:0] CMD_WB  = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OWN,
    ST_SNOOP,
    ST_MEMW,
    ST_HOLD
  } arb_state_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] pick,
  output logic          found
);
  always_comb begin
    int idx;
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/snoop_select.sv
module snoop_select #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  hits,
  output logic [IW-1:0] sel,
  output logic          any
);
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) sel = IW'(i);
    end
    any = |hits;
  end
endmodule

// File: rtl/snoop_bus_arbiter.sv
module snoop_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req,
  input  logic [3*N-1:0]  cmd_in,
  input  logic [AW*N-1:0] addr_in,
  input  logic [DW*N-1:0] wdata_in,
  output logic [N-1:0]    gnt,
  output logic            bus_valid,
  output logic [2:0]      bus_cmd,
  output logic [AW-1:0]   bus_addr,
  input  logic [N-1:0]    snp_avail,
  input  logic [N-1:0]    snp_wb,
  input  logic [DW*N-1:0] snp_data,
  output logic [N-1:0]    str_send,
  output logic [N-1:0]    str_rec,
  output logic [N-1:0]    cmd_rcv,
  output logic [N-1:0]    mdata_rdy,
  output logic [DW-1:0]   bus_rdata,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_rvld
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [N-1:0] ONE = N'(1);

  logic [2:0]    cmd_a   [N];
  logic [AW-1:0] addr_a  [N];
  logic [DW-1:0] wdata_a [N];
  logic [DW-1:0] sdata_a [N];

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign cmd_a[g]   = cmd_in[g*3 +: 3];
    assign addr_a[g]  = addr_in[g*AW +: AW];
    assign wdata_a[g] = wdata_in[g*DW +: DW];
    assign sdata_a[g] = snp_data[g*DW +: DW];
  end

  arb_state_e    state;
  logic [IW-1:0] owner;
  logic [IW-1:0] last;
  logic [IW-1:0] rr_pick;
  logic          rr_found;
  logic [IW-1:0] snp_sel;
  logic          snp_any;
  logic [2:0]    own_cmd;
  logic [N-1:0]  snp_hits;

  assign own_cmd  = cmd_a[owner];
  assign snp_hits = (snp_avail | snp_wb) & ~gnt;

  rr_arbiter #(.N(N), .IW(IW)) u_rr (
    .req(req), .last(last), .pick(rr_pick), .found(rr_found)
  );

  snoop_select #(.N(N), .IW(IW)) u_sel (
    .hits(snp_hits), .sel(snp_sel), .any(snp_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      owner     <= '0;
      last      <= IW'(N - 1);
      gnt       <= '0;
      bus_valid <= 1'b0;
      bus_cmd   <= CMD_REL;
      bus_addr  <= '0;
      str_send  <= '0;
      str_rec   <= '0;
      cmd_rcv   <= '0;
      mdata_rdy <= '0;
      bus_rdata <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      bus_valid <= 1'b0;
      str_send  <= '0;
      str_rec   <= '0;
      cmd_rcv   <= '0;
      mdata_rdy <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rr_found) begin
            owner <= rr_pick;
            gnt   <= ONE << rr_pick;
            state <= ST_OWN;
          end
        end
        ST_OWN: begin
          case (own_cmd)
            CMD_REL: begin
              gnt   <= '0;
              last  <= owner;
              state <= ST_IDLE;
            end
            CMD_WB: begin
              mem_wr    <= 1'b1;
              mem_addr  <= addr_a[owner];
              mem_wdata <= wdata_a[owner];
              state     <= ST_HOLD;
            end
            CMD_RDS, CMD_RDX, CMD_INV: begin
              bus_valid <= 1'b1;
              bus_cmd   <= own_cmd;
              bus_addr  <= addr_a[owner];
              state     <= ST_SNOOP;
            end
            default: state <= ST_OWN;
          endcase
        end
        ST_SNOOP: begin
          if (bus_cmd == CMD_INV) begin
            cmd_rcv <= gnt;
            state   <= ST_HOLD;
          end else if (snp_any) begin
            str_send  <= ONE << snp_sel;
            str_rec   <= gnt;
            cmd_rcv   <= gnt;
            bus_rdata <= sdata_a[snp_sel];
            if (snp_wb[snp_sel]) begin
              mem_wr    <= 1'b1;
              mem_addr  <= bus_addr;
              mem_wdata <= sdata_a[snp_sel];
            end
            state <= ST_HOLD;
          end else begin
            mem_rd   <= 1'b1;
            mem_addr <= bus_addr;
            state    <= ST_MEMW;
          end
        end
        ST_MEMW: begin
          if (mem_rvld) begin
            mdata_rdy <= gnt;
            cmd_rcv   <= gnt;
            bus_rdata <= mem_rdata;
            state     <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (own_cmd == CMD_REL) begin
            gnt   <= '0;
            last  <= owner;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_bus_arbiter_checker.sv
module snoop_bus_arbiter_checker #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   gnt,
  input logic [3*N-1:0] cmd_in,
  input logic           bus_valid,
  input logic [N-1:0]   str_send,
  input logic [N-1:0]   str_rec,
  input logic [N-1:0]   cmd_rcv,
  input logic [N-1:0]   mdata_rdy,
  input logic           mem_rd,
  input logic           mem_wr
);
  logic [2:0] oc;
  always_comb begin
    oc = 3'b000;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) oc = oc | cmd_in[i*3 +: 3];
    end
  end

  p_gnt_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  p_gnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ((|gnt) && (oc != 3'b000)) |=> (gnt == $past(gnt)));

  p_bcast_owned_r3: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (|gnt));

  p_one_src_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(str_send));

  p_peer_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (|str_rec) |-> ((cmd_rcv == str_rec) && (str_rec == gnt) && (|str_send) && !(|mdata_rdy)));

  p_mem_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (|mdata_rdy) |-> ((cmd_rcv == mdata_rdy) && (str_send == '0)));

  p_rd_after_snoop_r7: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> ($past(bus_valid) && !mem_wr));
endmodule

bind snoop_bus_arbiter snoop_bus_arbiter_checker #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .gnt(gnt), .cmd_in(cmd_in), .bus_valid(bus_valid),
  .str_send(str_send), .str_rec(str_rec), .cmd_rcv(cmd_rcv),
  .mdata_rdy(mdata_rdy), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/snoop_bus_arbiter_bench.sv
`timescale 1ns/1ps
module snoop_bus_arbiter_bench;
  localparam int N = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MEM_LAT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N-1:0] req = '0;
  logic [3*N-1:0] cmd_in = '0;
  logic [AW*N-1:0] addr_in = '0;
  logic [DW*N-1:0] wdata_in = '0;
  logic [N-1:0] gnt, str_send, str_rec, cmd_rcv, mdata_rdy;
  logic bus_valid, mem_rd, mem_wr;
  logic [2:0] bus_cmd;
  logic [AW-1:0] bus_addr, mem_addr;
  logic [DW-1:0] bus_rdata, mem_wdata;
  logic [N-1:0] snp_avail = '0, snp_wb = '0;
  logic [DW*N-1:0] snp_data;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_rvld = 1'b0;

  logic [N-1:0] plan_av = '0, plan_wb = '0;
  logic [DW-1:0] plan_base = '0;

  snoop_bus_arbiter #(.N(N), .AW(AW), .DW(DW)) u_snoop_bus_arbiter (
    .clk(clk), .rst(rst), .req(req), .cmd_in(cmd_in), .addr_in(addr_in),
    .wdata_in(wdata_in), .gnt(gnt), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .snp_avail(snp_avail), .snp_wb(snp_wb),
    .snp_data(snp_data), .str_send(str_send), .str_rec(str_rec),
    .cmd_rcv(cmd_rcv), .mdata_rdy(mdata_rdy), .bus_rdata(bus_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvld(mem_rvld)
  );

  int checks = 0;
  int fails = 0;
  int bm_last = N - 1;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int next_in(input logic [N-1:0] v, input int from);
    for (int k = 1; k <= N; k++) if (v[(from + k) % N]) return (from + k) % N;
    return -1;
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) snp_data[i*DW +: DW] = plan_base + DW'(i);
  end

  // snoopers answer only while the broadcast strobe is up
  always @(negedge clk) begin
    if (bus_valid) begin
      snp_avail <= plan_av;
      snp_wb    <= plan_wb;
    end else begin
      snp_avail <= '0;
      snp_wb    <= '0;
    end
  end

  // fixed-latency memory model
  int mcnt = 0;
  logic [AW-1:0] raddr_q = '0;
  always @(negedge clk) begin
    mem_rvld <= 1'b0;
    if (mem_rd) begin
      mcnt    <= MEM_LAT;
      raddr_q <= mem_addr;
    end else if (mcnt > 0) begin
      if (mcnt == 1) begin
        mem_rvld  <= 1'b1;
        mem_rdata <= mem_val(raddr_q);
      end
      mcnt <= mcnt - 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", rq, what);
    end
  endtask

  task automatic run_txn(input int o, input logic [2:0] c, input logic [AW-1:0] a,
                         input logic [N-1:0] av, input logic [N-1:0] wb,
                         input logic [DW-1:0] base, input logic [DW-1:0] wd);
    int cyc, bv_cyc, ack_cyc, mr_cnt, mw_cnt, sel;
    logic [2:0] bv_cmd;
    logic [AW-1:0] bv_addr, mr_addr, mw_addr;
    logic [DW-1:0] mw_data, ack_data;
    logic [N-1:0] ack_rcv, ack_rec, ack_mdr, ack_send, resp, own;
    int mw_cyc, bv_cnt;
    bit held_bad, gotg;
    own = N'(1) << o;
    bv_cyc = -1; ack_cyc = -1; mr_cnt = 0; mw_cnt = 0; mw_cyc = -1; bv_cnt = 0;
    bv_cmd = '0; bv_addr = '0; mr_addr = '0; mw_addr = '0; mw_data = '0;
    ack_data = '0; ack_rcv = '0; ack_rec = '0; ack_mdr = '0; ack_send = '0;
    held_bad = 0; gotg = 0;
    @(negedge clk);
    plan_av = av; plan_wb = wb; plan_base = base;
    req[o] = 1'b1;
    cmd_in[o*3 +: 3] = c;
    addr_in[o*AW +: AW] = a;
    wdata_in[o*DW +: DW] = wd;
    for (int w = 0; w < 20 && !gotg; w++) begin
      @(negedge clk);
      if (gnt == own) gotg = 1;
    end
    chk(gotg, "R1", $sformatf("single requester %0d granted: actual gnt=%b expected=%b", o, gnt, own));
    for (cyc = 0; cyc < 12 + MEM_LAT; cyc++) begin
      @(negedge clk);
      if (gnt != own) held_bad = 1;
      if (bus_valid) begin
        bv_cnt++;
        if (bv_cyc < 0) begin bv_cyc = cyc; bv_cmd = bus_cmd; bv_addr = bus_addr; end
      end
      if ((|cmd_rcv) && ack_cyc < 0) begin
        ack_cyc = cyc; ack_rcv = cmd_rcv; ack_rec = str_rec; ack_mdr = mdata_rdy;
        ack_send = str_send; ack_data = bus_rdata;
      end
      if (mem_rd) begin mr_cnt++; mr_addr = mem_addr; end
      if (mem_wr) begin mw_cnt++; mw_addr = mem_addr; mw_data = mem_wdata; mw_cyc = cyc; end
    end
    chk(!held_bad, "R2", $sformatf("grant held while cmd=%b: actual gnt=%b expected=%b", c, gnt, own));
    cmd_in[o*3 +: 3] = 3'b000;
    req[o] = 1'b0;
    @(negedge clk);
    chk(gnt == '0, "R2", $sformatf("grant after release: actual=%b expected=0000", gnt));
    bm_last = o;
    resp = (av | wb) & ~own;
    if (c == 3'b111) begin
      chk(bv_cnt == 0 && ack_cyc < 0 && mr_cnt == 0, "R9",
          $sformatf("writeback no bcast/ack: actual bv=%0d ack=%0d rd=%0d expected 0/-1/0", bv_cnt, ack_cyc, mr_cnt));
      chk(mw_cnt == 1 && mw_addr == a && mw_data == wd, "R9",
          $sformatf("writeback mem write: actual n=%0d a=%h d=%h expected 1 %h %h", mw_cnt, mw_addr, mw_data, a, wd));
      return;
    end
    chk(bv_cnt == 1 && bv_cmd == c && bv_addr == a, "R3",
        $sformatf("broadcast: actual n=%0d cmd=%b a=%h expected 1 %b %h", bv_cnt, bv_cmd, bv_addr, c, a));
    if (c == 3'b011) begin
      chk(ack_rcv == own && ack_rec == '0 && ack_mdr == '0 && ack_send == '0 && mr_cnt == 0 && mw_cnt == 0,
          "R8", $sformatf("invalidate: actual rcv=%b rec=%b mdr=%b send=%b rd=%0d wr=%0d expected rcv=%b rest 0",
          ack_rcv, ack_rec, ack_mdr, ack_send, mr_cnt, mw_cnt, own));
      return;
    end
    if (resp != '0) begin
      sel = lowest(resp);
      chk(ack_send == (N'(1) << sel), "R4",
          $sformatf("supplier pick: actual send=%b expected=%b", ack_send, N'(1) << sel));
      chk(ack_rcv == own && ack_rec == own && ack_mdr == '0 && ack_data == base + DW'(sel) && mr_cnt == 0,
          "R5", $sformatf("peer ack: actual rcv=%b rec=%b mdr=%b d=%h rd=%0d expected %b %b 0 %h 0",
          ack_rcv, ack_rec, ack_mdr, ack_data, mr_cnt, own, own, base + DW'(sel)));
      if (wb[sel])
        chk(mw_cnt == 1 && mw_cyc == ack_cyc && mw_addr == a && mw_data == base + DW'(sel), "R6",
            $sformatf("dirty supply wr: actual n=%0d cyc=%0d a=%h d=%h expected 1 %0d %h %h",
            mw_cnt, mw_cyc, mw_addr, mw_data, ack_cyc, a, base + DW'(sel)));
      else
        chk(mw_cnt == 0, "R6", $sformatf("clean supply wr: actual n=%0d expected 0", mw_cnt));
      chk(ack_cyc - bv_cyc == 1, "R10",
          $sformatf("peer latency: actual=%0d expected=1", ack_cyc - bv_cyc));
    end else begin
      chk(mr_cnt == 1 && mr_addr == a && mw_cnt == 0, "R7",
          $sformatf("mem read: actual n=%0d a=%h wr=%0d expected 1 %h 0", mr_cnt, mr_addr, mw_cnt, a));
      chk(ack_rcv == own && ack_mdr == own && ack_rec == '0 && ack_send == '0 && ack_data == mem_val(a),
          "R7", $sformatf("mem ack: actual rcv=%b mdr=%b rec=%b d=%h expected %b %b 0 %h",
          ack_rcv, ack_mdr, ack_rec, ack_data, own, own, mem_val(a)));
      chk(ack_cyc - bv_cyc == MEM_LAT + 2, "R10",
          $sformatf("mem latency: actual=%0d expected=%0d", ack_cyc - bv_cyc, MEM_LAT + 2));
    end
  endtask

  // release-only requesters: each grant lasts one cycle, order is checked
  task automatic rr_round(input logic [N-1:0] set, input int count);
    int exp_o, got, w;
    @(negedge clk);
    cmd_in = '0;
    req = set;
    for (int n = 0; n < count; n++) begin
      exp_o = next_in(set, bm_last);
      got = -1;
      for (w = 0; w < 10 && got < 0; w++) begin
        @(negedge clk);
        if (gnt != '0) got = lowest(gnt);
      end
      chk(got == exp_o && $countones(gnt) == 1, "R1",
          $sformatf("rotation set=%b: actual owner=%0d expected=%0d", set, got, exp_o));
      bm_last = exp_o;
    end
    req = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1: watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed, o, ci;
    logic [2:0] cl [4];
    cl[0] = 3'b001; cl[1] = 3'b010; cl[2] = 3'b011; cl[3] = 3'b111;
    seed = $urandom(32'h5eed_c0de);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(gnt == '0 && str_send == '0 && str_rec == '0 && cmd_rcv == '0 && mdata_rdy == '0
        && !bus_valid && !mem_rd && !mem_wr, "R11",
        $sformatf("reset state: actual gnt=%b rcv=%b bv=%b rd=%b wr=%b expected all 0",
        gnt, cmd_rcv, bus_valid, mem_rd, mem_wr));

    rr_round(4'b1111, 6);
    rr_round(4'b1010, 4);

    run_txn(0, 3'b001, 16'h00ff, 4'b0000, 4'b0000, 32'h1000_0000, 32'h0);
    run_txn(1, 3'b010, 16'h007f, 4'b1110, 4'b0000, 32'h2000_0000, 32'h0);
    run_txn(3, 3'b001, 16'h1234, 4'b0001, 4'b0010, 32'h3000_0000, 32'h0);
    run_txn(2, 3'b010, 16'hbeef, 4'b0000, 4'b1000, 32'h4000_0000, 32'h0);
    run_txn(0, 3'b010, 16'h0042, 4'b0100, 4'b0010, 32'h4800_0000, 32'h0);
    run_txn(2, 3'b011, 16'h0abc, 4'b1011, 4'b0001, 32'h5000_0000, 32'h0);
    run_txn(0, 3'b111, 16'h0055, 4'b1111, 4'b0000, 32'h6000_0000, 32'hcafe_f00d);
    run_txn(1, 3'b001, 16'h0077, 4'b0010, 4'b0010, 32'h7000_0000, 32'h0);

    for (int t = 0; t < 60; t++) begin
      o = int'($urandom % N);
      ci = int'($urandom % 4);
      run_txn(o, cl[ci], AW'($urandom), N'($urandom),
              (($urandom % 3) == 0) ? N'($urandom) : N'(0), $urandom, $urandom);
      if ((t % 15) == 14) rr_round(N'($urandom % 15 + 1), 5);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule